// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Timer

This block keeps a free-running count of microseconds while it runs from a fast reference clock. The reference clock does not need to be an integer multiple of 1 MHz. A fractional rate generator sits between the clock and the counter. Each enabled reference cycle adds a programmable step, M+1, to an accumulator. Each time the accumulator reaches the modulus N+1, the generator removes the modulus and sends one increment to the counter. The counter therefore advances at the reference rate times (M+1)/(N+1). Settings such as 0x043F at 12.8 MHz or 0x04BF at 38.4 MHz give exactly one count per microsecond.

Software reaches the block through a one-bit register address. Address 0 reads the count. Address 1 reads and writes the 16-bit ratio word. A block-level enable input gates all progress. While the enable is low, both the accumulator and the count hold their values.

Top module: `frac_usec_timer`

## Requirements
- R1: After reset the count reads 0 and the ratio word reads 0x000C: step field M=0 in bits [15:8] and modulus field N=12 in bits [7:0]. This gives one increment per 13 enabled cycles.
- R2: A write with regAddr=1 loads regWdata[15:7+1] into M and regWdata[7:0] into N. A read at regAddr=1 returns the ratio word zero-extended to 32 bits. A read at regAddr=0 returns the count.
- R3: Over K enabled cycles that start from a cleared accumulator, the count grows by exactly floor(K*(M+1)/(N+1)), provided M <= N.
- R4: Each of the settings 0x043F, 0x045F, 0x04BF and 0x000B gives a count within one of the ideal 1 MHz value over a window of reference cycles sized for its reference (12.8, 19.2, 38.4 and 12 MHz).
- R5: In any cycle the count advances by either 0 or exactly 1.
- R6: While clkEn is low the count and the accumulator hold. Progress resumes from where it stopped.
- R7: A write to the ratio word clears the accumulator and leaves the count unchanged.
- R8: The count wraps from its all-ones value to 0 and raises no flag.
- R9: When M equals N, the count advances on every enabled cycle.
- R10: A write with regAddr=0 has no effect: the count and the ratio word keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Block enable; the timer progresses only while this is high |
| regAddr | input | 1 | Register select: 0 selects the count, 1 selects the ratio word |
| regWr | input | 1 | Write strobe, sampled on the rising clock edge |
| regWdata | input | 32 | Write data; bits [15:0] are used for the ratio word |
| regRdata | output | 32 | Read data for the selected register, zero-extended |

## Verification
If the accumulator is corrupted, the effect appears at the read port as a phase error. The first increment after a ratio write comes earlier or later than floor(K*(M+1)/(N+1)) predicts. The bench can see this within one modulus period, at most 256 enabled cycles. A rate error from a wrong step or modulus grows linearly. The long windows run with the 1 MHz settings therefore show it as a count off by several ticks, not just one. If the enable gating or the clear-on-write is broken, an increment appears exactly one cycle too early in the short directed windows that end just before a modulus boundary.

// File: rtl/fut_pkg.sv
package fut_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam int BUS_W   = 32;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h000C;

  typedef struct packed {
    logic tick;   // advance the count this edge
    logic rdCfg;  // read mux selects the ratio word
  } futStrobeT;
endpackage

// File: rtl/fut_rate_ctrl.sv
module fut_rate_ctrl
  import fut_pkg::*;
#(
  parameter int F_W = FIELD_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkEn,
  input  logic               regAddr,
  input  logic               regWr,
  input  logic [2*F_W-1:0]   cfgWdata,
  output logic [2*F_W-1:0]   cfgQ,
  output logic [F_W:0]       accQ,
  output futStrobeT          strobe
);
  localparam int SUM_W = F_W + 2;

  logic             cfgWr;
  logic [F_W-1:0]   mFld;
  logic [F_W-1:0]   nFld;
  logic [SUM_W-1:0] step;
  logic [SUM_W-1:0] modulus;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] accNext;
  logic             wrap;

  assign cfgWr   = regWr && regAddr;
  assign mFld    = cfgQ[2*F_W-1:F_W];
  assign nFld    = cfgQ[F_W-1:0];
  assign step    = {2'b00, mFld} + SUM_W'(1);
  assign modulus = {2'b00, nFld} + SUM_W'(1);
  assign sum     = {1'b0, accQ} + step;
  assign wrap    = clkEn && !cfgWr && (sum >= modulus);

  always_comb begin
    accNext = sum;
    if (wrap) accNext = sum - modulus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= CFG_RESET[2*F_W-1:0];
      accQ <= '0;
    end else if (cfgWr) begin
      cfgQ <= cfgWdata;
      accQ <= '0;
    end else if (clkEn) begin
      accQ <= accNext[F_W:0];
    end
  end

  assign strobe.tick  = wrap;
  assign strobe.rdCfg = regAddr;
endmodule

// File: rtl/fut_count_path.sv
module fut_count_path
  import fut_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CW    = CFG_W,
  parameter int RD_W  = BUS_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  futStrobeT       strobe,
  input  logic [CW-1:0]   cfgVal,
  output logic [CNT_W-1:0] countQ,
  output logic [RD_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            countQ <= '0;
    else if (strobe.tick) countQ <= countQ + CNT_W'(1);
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdCfg) rdData[CW-1:0]    = cfgVal;
    else              rdData[CNT_W-1:0] = countQ;
  end
endmodule

// File: rtl/frac_usec_timer.sv
module frac_usec_timer
  import fut_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              regAddr,
  input  logic              regWr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata
);
  futStrobeT          strobe;
  logic [CFG_W-1:0]   cfgQ;
  logic [FIELD_W:0]   accQ;
  logic [CNT_W-1:0]   countQ;

  fut_rate_ctrl #(.F_W(FIELD_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .cfgWdata (regWdata[CFG_W-1:0]),
    .cfgQ     (cfgQ),
    .accQ     (accQ),
    .strobe   (strobe)
  );

  fut_count_path #(.CNT_W(CNT_W), .CW(CFG_W), .RD_W(BUS_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgVal (cfgQ),
    .countQ (countQ),
    .rdData (regRdata)
  );
endmodule

// File: rtl/frac_usec_timer_chk.sv
module frac_usec_timer_chk
  import fut_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              regAddr,
  input logic              regWr,
  input logic              tick,
  input logic [CNT_W-1:0]  countQ,
  input logic [FIELD_W:0]  accQ,
  input logic [CFG_W-1:0]  cfgQ
);
  p_reset_default_r1: assert property (@(posedge clk)
    !rstN |=> (cfgQ == CFG_RESET && countQ == '0));

  p_acc_below_mod_r3: assert property (@(posedge clk) disable iff (!rstN)
    accQ <= (FIELD_W+1)'(cfgQ[FIELD_W-1:0]));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> countQ == CNT_W'($past(countQ) + CNT_W'(1)));

  p_count_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(countQ));

  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(countQ) && ($stable(accQ) || accQ == '0)));

  p_tick_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> clkEn);

  p_cfg_clears_acc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr) |=> (accQ == '0 && $stable(countQ)));

  p_cnt_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regAddr) |=> $stable(cfgQ));
endmodule

bind frac_usec_timer frac_usec_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .clkEn   (clkEn),
  .regAddr (regAddr),
  .regWr   (regWr),
  .tick    (strobe.tick),
  .countQ  (countQ),
  .accQ    (accQ),
  .cfgQ    (cfgQ)
);

// File: tb/tb_frac_usec_timer.sv
module tb_frac_usec_timer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        clkEn, regAddr, regWr;
  logic [31:0] regWdata, regRdata;
  logic        nEn, nAddr, nWr;
  logic [31:0] nWdata, nRdata;

  int checks = 0;
  int errors = 0;

  localparam int NVEC = 5;
  localparam logic [15:0] VEC_CFG [NVEC] = '{16'h043F, 16'h045F, 16'h04BF, 16'h000B, 16'h0305};
  localparam int          VEC_CYC [NVEC] = '{6400, 9600, 19200, 6000, 100};
  localparam int          VEC_US  [NVEC] = '{500, 500, 500, 500, -1};

  always #4 clk = ~clk;

  frac_usec_timer dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata));

  frac_usec_timer #(.CNT_W(8)) dutNarrow (
    .clk(clk), .rstN(rstN), .clkEn(nEn), .regAddr(nAddr),
    .regWr(nWr), .regWdata(nWdata), .regRdata(nRdata));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic runEn(input int n);
    @(negedge clk);
    clkEn = 1'b1;
    repeat (n) @(negedge clk);
    clkEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, base, c2;
    rstN = 1'b0; clkEn = 1'b0; regAddr = 1'b0; regWr = 1'b0; regWdata = '0;
    nEn = 1'b0; nAddr = 1'b0; nWr = 1'b0; nWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(1'b0, v); check("R1 count after reset", v, 0);
    rdReg(1'b1, v); check("R1 ratio word after reset", v, 32'h0000000C);

    // R3 default ratio 1/13
    runEn(26);
    rdReg(1'b0, v); check("R3 default 26 cycles", v, 2);

    // R6 enable low holds count
    repeat (50) @(negedge clk);
    rdReg(1'b0, v); check("R6 count held while disabled", v, 2);

    // R6 accumulator frozen while disabled
    wrReg(1'b1, 32'h0000000C);
    runEn(12);
    repeat (40) @(negedge clk);
    rdReg(1'b0, v); check("R6 no tick before boundary", v, 2);
    runEn(1);
    rdReg(1'b0, v); check("R6 resumes at saved phase", v, 3);

    // R7 ratio write clears accumulator, keeps count
    runEn(12);
    wrReg(1'b1, 32'h0000000C);
    rdReg(1'b0, v); check("R7 count kept on ratio write", v, 3);
    runEn(12);
    rdReg(1'b0, v); check("R7 phase restarted", v, 3);
    runEn(1);
    rdReg(1'b0, v); check("R7 first tick after 13", v, 4);

    // R10 write to count address ignored
    wrReg(1'b0, 32'hDEADBEEF);
    rdReg(1'b0, v); check("R10 count unchanged", v, 4);
    rdReg(1'b1, v); check("R10 ratio unchanged", v, 32'h0000000C);

    // R2 ratio field load and readback
    wrReg(1'b1, 32'hABCD1234);
    rdReg(1'b1, v); check("R2 ratio readback", v, 32'h00001234);

    // R9 M equal N full rate, R5 one per cycle
    wrReg(1'b1, 32'h00000707);
    rdReg(1'b0, base);
    runEn(20);
    rdReg(1'b0, v); check("R9 M=N full rate", v - base, 20);

    // R3 / R4 table of ratio settings
    for (int i = 0; i < NVEC; i++) begin
      longint m, n, ideal, diff;
      wrReg(1'b1, {16'h0, VEC_CFG[i]});
      rdReg(1'b0, base);
      runEn(VEC_CYC[i]);
      rdReg(1'b0, c2);
      m = longint'(VEC_CFG[i][15:8]);
      n = longint'(VEC_CFG[i][7:0]);
      ideal = (longint'(VEC_CYC[i]) * (m + 1)) / (n + 1);
      check($sformatf("R3 ratio %h", VEC_CFG[i]), c2 - base, ideal);
      if (VEC_US[i] >= 0) begin
        diff = longint'(c2 - base) - longint'(VEC_US[i]);
        check($sformatf("R4 1MHz setting %h within one", VEC_CFG[i]),
              (diff <= 1 && diff >= -1) ? 1 : 0, 1);
      end
    end

    // R8 wrap on narrow instance
    @(negedge clk);
    nAddr = 1'b1; nWr = 1'b1; nWdata = 32'h0;
    @(negedge clk);
    nWr = 1'b0; nAddr = 1'b0;
    nEn = 1'b1;
    repeat (255) @(negedge clk);
    nEn = 1'b0;
    #1 check("R8 count at all ones", nRdata, 255);
    @(negedge clk);
    nEn = 1'b1;
    @(negedge clk);
    nEn = 1'b0;
    #1 check("R8 wrap to zero", nRdata, 0);
    @(negedge clk);
    nEn = 1'b1;
    repeat (3) @(negedge clk);
    nEn = 1'b0;
    #1 check("R8 counts on after wrap", nRdata, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule